// File: doc/BRIEF.md
# Memory-Operand Instruction Decoder with Extension Words

This block decodes a stream of 32-bit instruction words for a register-memory machine in which each instruction may carry at most one memory operand. An instruction word is split into its opcode, operation size, secondary opcode bits, two routing fields, an addressing mode and three 5-bit register fields. One routing field says which register field is a small signed immediate rather than a register number. The other says which register field names the memory operand.

The addressing mode sets how many trailing 32-bit extension words follow the instruction: none, one or two. The decoder absorbs them and then issues one decoded record. The record carries the assembled displacement or absolute address, the sign-extended immediate, and a base-register writeback request with its byte step for the auto-increment and auto-decrement modes. A malformed routing combination is flagged as illegal instead of being decoded.

The control is a three-state machine. ST_OPWORD waits for an instruction word. ST_EXT_LO takes the first extension word. ST_EXT_HI takes the second, high-order extension word. The transitions are:
- OP_DONE (ST_OPWORD to ST_OPWORD): a legal instruction with no extension words, or an illegal one.
- OP_NEED_EXT (ST_OPWORD to ST_EXT_LO): the mode needs extension words.
- LO_DONE (ST_EXT_LO to ST_OPWORD): the mode needs exactly one word.
- LO_MORE (ST_EXT_LO to ST_EXT_HI): the mode needs two words.
- HI_DONE (ST_EXT_HI to ST_OPWORD): the second word has arrived.
- WAIT: any state holds while `in_valid` is low.

Top module: `memop_decoder`

## Requirements
- R1: The instruction word is split, from bit 31 down, into opcode [31:26], size [25:24], secondary opcode [23:22], immediate route [21:20], memory route [19:18], mode [17:15], source A [14:10], source B [9:5] and destination [4:0]. Opcode, size, secondary opcode, mode and the three register fields appear unchanged in the record.
- R2: Immediate route 0 means no immediate. Route 1 selects source A and route 2 selects source B. With route 1 or 2, `out_imm_valid` is 1 and `out_imm` is the selected 5-bit field sign-extended to 64 bits. Otherwise `out_imm` is 0.
- R3: Memory route 0 means no memory operand. Route 1 selects source A, route 2 selects source B and route 3 selects the destination. With a nonzero route, `out_mem_valid` is 1 and `out_mem_reg` is that field. Otherwise `out_mem_reg` is 0.
- R4: An instruction is illegal when its immediate route is 3, or when both routes are equal and nonzero. One cycle after it is accepted, `out_illegal` pulses for one cycle with no record. No extension words are absorbed, so the next word is taken as a new instruction.
- R5: Modes 0 (register direct), 1 (indirect), 2 (post-increment) and 3 (pre-decrement) take no extension words. The record appears one cycle after the instruction word is accepted.
- R6: Mode 4 (32-bit displacement) and mode 6 (32-bit absolute) take one extension word. The record appears one cycle after that word. Mode 4 sign-extends the word into `out_disp` and mode 6 zero-extends it. `out_absolute` is 1 for mode 6.
- R7: Mode 5 (64-bit displacement) and mode 7 (64-bit absolute) take two extension words, low half first. `out_disp` is {second, first}. `out_absolute` is 1 for mode 7.
- R8: `in_ready` is 1 whenever reset is released, including while extension words are being collected. A word accepted mid-sequence is always treated as an extension word, and no record is issued before the final word.
- R9: With a memory operand and mode 2 or 3, `out_wb_en` is 1 and `out_wb_step` equals 1, 2, 4 or 8 for size 0, 1, 2 or 3. Otherwise both are 0.
- R10: In mode 3, `out_disp` is the negative of the size step, so it gives the access offset after adjustment. In modes 0 to 2, `out_disp` is 0.
- R11: While reset is asserted and after it is released, `out_valid` and `out_illegal` are 0. A sequence cut short by reset is abandoned, and the next word is taken as an instruction.
- R12: Cycles with `in_valid` low, including gaps between extension words, change neither the state nor the assembled value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Decoder accepts a word |
| in_word | input | 32 | Instruction or extension word |
| out_valid | output | 1 | One-cycle pulse: decoded record valid |
| out_illegal | output | 1 | One-cycle pulse: illegal instruction |
| out_opcode | output | 6 | Opcode |
| out_xop | output | 2 | Secondary opcode bits |
| out_size | output | 2 | Operation size code |
| out_mode | output | 3 | Addressing mode |
| out_src_a | output | 5 | Source A field |
| out_src_b | output | 5 | Source B field |
| out_dst | output | 5 | Destination field |
| out_imm_valid | output | 1 | An immediate is present |
| out_imm | output | 64 | Sign-extended immediate |
| out_mem_valid | output | 1 | A memory operand is present |
| out_mem_reg | output | 5 | Register field naming the memory operand |
| out_absolute | output | 1 | `out_disp` is an absolute address |
| out_disp | output | 64 | Assembled displacement, address or access offset |
| out_wb_en | output | 1 | Base register writeback requested |
| out_wb_step | output | 4 | Writeback step in bytes |

## Verification
The assertions assume that `in_word` is meaningful only while `in_valid` is high. They also assume that a producer always follows an instruction with exactly the number of extension words its mode implies, because the decoder cannot tell an extension word from an instruction. The stimulus keeps to this rule: every table entry and every directed case sends the full word count for its mode. The only exceptions are the illegal cases, which by R4 send none, and a deliberate reset in the middle of a sequence. Gaps with `in_valid` low are inserted only between words of one instruction, never inside a word.

// File: rtl/memop_pkg.sv
package memop_pkg;

    localparam int WORD_W  = 32;
    localparam int XLEN    = 64;
    localparam int RF_W    = 5;
    localparam int OPC_W   = 6;
    localparam int STEP_W  = 4;

    typedef enum logic [1:0] {
        RT_NONE = 2'd0,
        RT_A    = 2'd1,
        RT_B    = 2'd2,
        RT_D    = 2'd3
    } route_e;

    typedef enum logic [2:0] {
        AM_REG     = 3'd0,
        AM_IND     = 3'd1,
        AM_POSTINC = 3'd2,
        AM_PREDEC  = 3'd3,
        AM_DISP32  = 3'd4,
        AM_DISP64  = 3'd5,
        AM_ABS32   = 3'd6,
        AM_ABS64   = 3'd7
    } amode_e;

    typedef enum logic [1:0] {
        ST_OPWORD = 2'd0,
        ST_EXT_LO = 2'd1,
        ST_EXT_HI = 2'd2
    } dec_state_e;

    typedef enum logic [1:0] {
        SRC_OP = 2'd0,
        SRC_LO = 2'd1,
        SRC_HI = 2'd2
    } emit_src_e;

    // field order is the bit order of the instruction word
    typedef struct packed {
        logic [OPC_W-1:0] opcode;
        logic [1:0]       size;
        logic [1:0]       xop;
        route_e           imm_route;
        route_e           mem_route;
        amode_e           mode;
        logic [RF_W-1:0]  ra;
        logic [RF_W-1:0]  rb;
        logic [RF_W-1:0]  rd;
    } opword_t;

    typedef struct packed {
        logic [OPC_W-1:0]  opcode;
        logic [1:0]        xop;
        logic [1:0]        size;
        amode_e            mode;
        logic [RF_W-1:0]   ra;
        logic [RF_W-1:0]   rb;
        logic [RF_W-1:0]   rd;
        logic              imm_valid;
        logic [XLEN-1:0]   imm;
        logic              mem_valid;
        logic [RF_W-1:0]   mem_reg;
        logic              absolute;
        logic [XLEN-1:0]   disp;
        logic              wb_en;
        logic [STEP_W-1:0] wb_step;
    } uop_t;

    function automatic logic [XLEN-1:0] sext_field(input logic [RF_W-1:0] f);
        return {{(XLEN-RF_W){f[RF_W-1]}}, f};
    endfunction

endpackage

// File: rtl/memop_field_decode.sv
module memop_field_decode
    import memop_pkg::*;
(
    input  opword_t    word,
    output uop_t       uop,
    output logic [1:0] ext_cnt,
    output logic       illegal
);

    logic [STEP_W-1:0] step;
    logic              auto_mode;

    always_comb begin
        step      = STEP_W'(1) << word.size;
        auto_mode = (word.mode == AM_POSTINC) || (word.mode == AM_PREDEC);

        illegal = (word.imm_route == RT_D) ||
                  ((word.imm_route != RT_NONE) && (word.imm_route == word.mem_route));

        unique case (word.mode)
            AM_DISP32, AM_ABS32: ext_cnt = 2'd1;
            AM_DISP64, AM_ABS64: ext_cnt = 2'd2;
            default:             ext_cnt = 2'd0;
        endcase

        uop.opcode   = word.opcode;
        uop.xop      = word.xop;
        uop.size     = word.size;
        uop.mode     = word.mode;
        uop.ra       = word.ra;
        uop.rb       = word.rb;
        uop.rd       = word.rd;
        uop.absolute = (word.mode == AM_ABS32) || (word.mode == AM_ABS64);

        unique case (word.imm_route)
            RT_A: begin
                uop.imm_valid = 1'b1;
                uop.imm       = sext_field(word.ra);
            end
            RT_B: begin
                uop.imm_valid = 1'b1;
                uop.imm       = sext_field(word.rb);
            end
            default: begin
                uop.imm_valid = 1'b0;
                uop.imm       = '0;
            end
        endcase

        unique case (word.mem_route)
            RT_A:    uop.mem_reg = word.ra;
            RT_B:    uop.mem_reg = word.rb;
            RT_D:    uop.mem_reg = word.rd;
            default: uop.mem_reg = '0;
        endcase
        uop.mem_valid = (word.mem_route != RT_NONE);

        uop.wb_en   = uop.mem_valid && auto_mode;
        uop.wb_step = uop.wb_en ? step : '0;

        // extension-word modes overwrite disp later in the top
        if (word.mode == AM_PREDEC) uop.disp = XLEN'(0) - XLEN'(step);
        else                        uop.disp = '0;
    end

    always_comb begin
        if (uop.wb_en) begin
            AST_STEP_ONEHOT: assert ($countones(uop.wb_step) == 1); // R9
        end
    end

endmodule

// File: rtl/memop_seq_ctrl.sv
module memop_seq_ctrl
    import memop_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [1:0] ext_cnt,
    input  logic       illegal,
    output logic       in_ready,
    output logic       take_op,
    output logic       take_lo,
    output logic       emit,
    output logic       flag_illegal,
    output emit_src_e  emit_src
);

    dec_state_e state, state_nx;
    logic       need_hi_q;
    logic       accept;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_OPWORD;
            need_hi_q <= 1'b0;
        end else begin
            state <= state_nx;
            if (take_op) need_hi_q <= (ext_cnt == 2'd2);
        end
    end

    // next state: OP_DONE, OP_NEED_EXT, LO_DONE, LO_MORE, HI_DONE, WAIT
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OPWORD: if (in_valid && !illegal && ext_cnt != 2'd0) state_nx = ST_EXT_LO;
            ST_EXT_LO: if (in_valid) state_nx = need_hi_q ? ST_EXT_HI : ST_OPWORD;
            ST_EXT_HI: if (in_valid) state_nx = ST_OPWORD;
            default:   state_nx = ST_OPWORD;
        endcase
    end

    // outputs
    always_comb begin
        in_ready     = rst_n;
        accept       = in_valid && in_ready;
        take_op      = 1'b0;
        take_lo      = 1'b0;
        emit         = 1'b0;
        flag_illegal = 1'b0;
        emit_src     = SRC_OP;
        unique case (state)
            ST_OPWORD: begin
                take_op      = accept;
                flag_illegal = accept && illegal;
                emit         = accept && !illegal && (ext_cnt == 2'd0);
                emit_src     = SRC_OP;
            end
            ST_EXT_LO: begin
                take_lo  = accept;
                emit     = accept && !need_hi_q;
                emit_src = SRC_LO;
            end
            ST_EXT_HI: begin
                emit     = accept;
                emit_src = SRC_HI;
            end
            default: ;
        endcase
    end

    AST_HI_FOLLOWS_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXT_HI && $past(state) != ST_EXT_HI) |-> $past(state) == ST_EXT_LO); // R7

    AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && state != ST_OPWORD) |=> $stable(state)); // R12

endmodule

// File: rtl/memop_decoder.sv
module memop_decoder
    import memop_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_word,
    output logic              out_valid,
    output logic              out_illegal,
    output logic [OPC_W-1:0]  out_opcode,
    output logic [1:0]        out_xop,
    output logic [1:0]        out_size,
    output logic [2:0]        out_mode,
    output logic [RF_W-1:0]   out_src_a,
    output logic [RF_W-1:0]   out_src_b,
    output logic [RF_W-1:0]   out_dst,
    output logic              out_imm_valid,
    output logic [XLEN-1:0]   out_imm,
    output logic              out_mem_valid,
    output logic [RF_W-1:0]   out_mem_reg,
    output logic              out_absolute,
    output logic [XLEN-1:0]   out_disp,
    output logic              out_wb_en,
    output logic [STEP_W-1:0] out_wb_step
);

    uop_t              dec_uop;
    logic [1:0]        ext_cnt;
    logic              illegal;
    logic              take_op, take_lo, emit, flag_illegal;
    emit_src_e         emit_src;
    uop_t              pend_q;
    logic [WORD_W-1:0] lo_q;
    uop_t              rec_nx, rec_q;
    logic              valid_q, illegal_q;

    memop_field_decode u_fields (
        .word    (opword_t'(in_word)),
        .uop     (dec_uop),
        .ext_cnt (ext_cnt),
        .illegal (illegal)
    );

    memop_seq_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .ext_cnt      (ext_cnt),
        .illegal      (illegal),
        .in_ready     (in_ready),
        .take_op      (take_op),
        .take_lo      (take_lo),
        .emit         (emit),
        .flag_illegal (flag_illegal),
        .emit_src     (emit_src)
    );

    always_comb begin
        rec_nx = pend_q;
        unique case (emit_src)
            SRC_OP: rec_nx = dec_uop;
            SRC_LO: begin
                if (pend_q.mode == AM_ABS32)
                    rec_nx.disp = {{(XLEN-WORD_W){1'b0}}, in_word};
                else
                    rec_nx.disp = {{(XLEN-WORD_W){in_word[WORD_W-1]}}, in_word};
            end
            SRC_HI: rec_nx.disp = {in_word, lo_q};
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q   <= 1'b0;
            illegal_q <= 1'b0;
            rec_q     <= '0;
            pend_q    <= '0;
            lo_q      <= '0;
        end else begin
            valid_q   <= emit;
            illegal_q <= flag_illegal;
            if (emit)    rec_q  <= rec_nx;
            if (take_op) pend_q <= dec_uop;
            if (take_lo) lo_q   <= in_word;
        end
    end

    assign out_valid     = valid_q;
    assign out_illegal   = illegal_q;
    assign out_opcode    = rec_q.opcode;
    assign out_xop       = rec_q.xop;
    assign out_size      = rec_q.size;
    assign out_mode      = rec_q.mode;
    assign out_src_a     = rec_q.ra;
    assign out_src_b     = rec_q.rb;
    assign out_dst       = rec_q.rd;
    assign out_imm_valid = rec_q.imm_valid;
    assign out_imm       = rec_q.imm;
    assign out_mem_valid = rec_q.mem_valid;
    assign out_mem_reg   = rec_q.mem_reg;
    assign out_absolute  = rec_q.absolute;
    assign out_disp      = rec_q.disp;
    assign out_wb_en     = rec_q.wb_en;
    assign out_wb_step   = rec_q.wb_step;

    AST_OUT_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid || out_illegal) |-> $past(in_valid && in_ready)); // R8

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && out_illegal)); // R4

    AST_WB_ONLY_AUTO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_wb_en) |-> (out_mode == 3'd2 || out_mode == 3'd3) && out_mem_valid); // R9

    AST_READY_OUT_OF_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready); // R8

endmodule

// File: tb/memop_decoder_tb.sv
`timescale 1ns/1ps
module memop_decoder_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_word = '0;
    logic        out_valid, out_illegal;
    logic [5:0]  out_opcode;
    logic [1:0]  out_xop, out_size;
    logic [2:0]  out_mode;
    logic [4:0]  out_src_a, out_src_b, out_dst;
    logic        out_imm_valid, out_mem_valid, out_absolute, out_wb_en;
    logic [63:0] out_imm, out_disp;
    logic [4:0]  out_mem_reg;
    logic [3:0]  out_wb_step;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    memop_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
        .out_valid(out_valid), .out_illegal(out_illegal), .out_opcode(out_opcode),
        .out_xop(out_xop), .out_size(out_size), .out_mode(out_mode),
        .out_src_a(out_src_a), .out_src_b(out_src_b), .out_dst(out_dst),
        .out_imm_valid(out_imm_valid), .out_imm(out_imm), .out_mem_valid(out_mem_valid),
        .out_mem_reg(out_mem_reg), .out_absolute(out_absolute), .out_disp(out_disp),
        .out_wb_en(out_wb_en), .out_wb_step(out_wb_step)
    );

    // {instruction, first extension, second extension}
    localparam int NV = 11;
    localparam logic [95:0] VEC [NV] = '{
        {{6'h05,2'd2,2'd1,2'd1,2'd2,3'd0,5'h1F,5'd3,5'd4},  32'h0,         32'h0},
        {{6'h3F,2'd0,2'd0,2'd0,2'd1,3'd1,5'd7,5'd9,5'd2},   32'h0,         32'h0},
        {{6'h11,2'd1,2'd2,2'd1,2'd2,3'd2,5'h0F,5'd12,5'd1}, 32'h0,         32'h0},
        {{6'h12,2'd3,2'd0,2'd0,2'd3,3'd3,5'd1,5'd2,5'd30},  32'h0,         32'h0},
        {{6'h20,2'd2,2'd3,2'd0,2'd1,3'd4,5'd5,5'd6,5'd7},   32'h8000_0010, 32'h0},
        {{6'h21,2'd2,2'd0,2'd2,2'd3,3'd6,5'd5,5'h11,5'd7},  32'h8000_0010, 32'h0},
        {{6'h22,2'd3,2'd1,2'd0,2'd2,3'd5,5'd1,5'd8,5'd3},   32'h1234_5678, 32'h9ABC_DEF0},
        {{6'h23,2'd3,2'd0,2'd1,2'd0,3'd7,5'd3,5'd8,5'd3},   32'hDEAD_BEEF, 32'h0000_0001},
        {{6'h13,2'd0,2'd0,2'd2,2'd1,3'd3,5'd9,5'd4,5'd0},   32'h0,         32'h0},
        {{6'h14,2'd2,2'd0,2'd1,2'd0,3'd3,5'd6,5'd4,5'd0},   32'h0,         32'h0},
        {{6'h15,2'd1,2'd0,2'd2,2'd1,3'd0,5'd6,5'h10,5'd0},  32'h0,         32'h0}
    };

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [63:0] sx5(input logic [4:0] f);
        return {{59{f[4]}}, f};
    endfunction

    function automatic int words_for(input logic [2:0] m);
        if (m == 3'd4 || m == 3'd6) return 1;
        if (m == 3'd5 || m == 3'd7) return 2;
        return 0;
    endfunction

    // expected record from the requirements; called at the negedge where out_valid is high
    task automatic check_record(input logic [31:0] w, input logic [31:0] e0, input logic [31:0] e1);
        logic [1:0]  ir, mr, sz;
        logic [2:0]  md;
        logic [3:0]  step;
        logic [63:0] exp_imm, exp_disp;
        logic [4:0]  exp_mreg;
        logic        exp_wb;
        ir = w[21:20]; mr = w[19:18]; sz = w[25:24]; md = w[17:15];
        step = 4'd1 << sz;
        exp_imm  = (ir == 2'd1) ? sx5(w[14:10]) : (ir == 2'd2) ? sx5(w[9:5]) : 64'd0;
        exp_mreg = (mr == 2'd1) ? w[14:10] : (mr == 2'd2) ? w[9:5] : (mr == 2'd3) ? w[4:0] : 5'd0;
        exp_wb   = (mr != 2'd0) && (md == 3'd2 || md == 3'd3);
        case (md)
            3'd3:       exp_disp = 64'd0 - 64'(step);
            3'd4:       exp_disp = {{32{e0[31]}}, e0};
            3'd6:       exp_disp = {32'd0, e0};
            3'd5, 3'd7: exp_disp = {e1, e0};
            default:    exp_disp = 64'd0;
        endcase
        chk("R5 out_valid", 64'(out_valid), 64'd1);
        chk("R1 opcode", 64'(out_opcode), 64'(w[31:26]));
        chk("R1 size", 64'(out_size), 64'(sz));
        chk("R1 xop", 64'(out_xop), 64'(w[23:22]));
        chk("R1 mode", 64'(out_mode), 64'(md));
        chk("R1 fields", {49'd0, out_src_a, out_src_b, out_dst}, {49'd0, w[14:0]});
        chk("R2 imm_valid", 64'(out_imm_valid), 64'(ir != 2'd0));
        chk("R2 imm", out_imm, exp_imm);
        chk("R3 mem_valid", 64'(out_mem_valid), 64'(mr != 2'd0));
        chk("R3 mem_reg", 64'(out_mem_reg), 64'(exp_mreg));
        chk("R9 wb_en", 64'(out_wb_en), 64'(exp_wb));
        chk("R9 wb_step", 64'(out_wb_step), exp_wb ? 64'(step) : 64'd0);
        chk("R6 R7 absolute", 64'(out_absolute), 64'(md == 3'd6 || md == 3'd7));
        chk("R10 R6 R7 disp", out_disp, exp_disp);
    endtask

    // sends an instruction with its extension words; gap idle cycles before each extension word
    task automatic send_insn(input logic [31:0] w, input logic [31:0] e0, input logic [31:0] e1,
                             input int gap);
        int n;
        n = words_for(w[17:15]);
        @(negedge clk);
        in_valid = 1'b1; in_word = w;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            chk("R8 no record mid-sequence", 64'(out_valid), 64'd0);
            chk("R8 ready mid-sequence", 64'(in_ready), 64'd1);
            if (gap > 0) begin
                in_valid = 1'b0; in_word = 32'hFFFF_FFFF;
                for (int g = 0; g < gap; g++) begin
                    @(negedge clk);
                    chk("R12 no record during gap", 64'(out_valid), 64'd0);
                end
            end
            in_valid = 1'b1;
            in_word  = (k == 0) ? e0 : e1;
        end
        @(negedge clk);
        in_valid = 1'b0;
        check_record(w, e0, e1);
        chk("R4 no illegal on legal word", 64'(out_illegal), 64'd0);
    endtask

    task automatic send_illegal(input logic [31:0] w);
        @(negedge clk);
        in_valid = 1'b1; in_word = w;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R4 illegal pulse", 64'(out_illegal), 64'd1);
        chk("R4 no record", 64'(out_valid), 64'd0);
        @(negedge clk);
        chk("R4 pulse one cycle", 64'(out_illegal), 64'd0);
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R11: reset state
        repeat (3) @(negedge clk);
        chk("R11 valid in reset", 64'(out_valid), 64'd0);
        chk("R11 illegal in reset", 64'(out_illegal), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 valid after reset", 64'(out_valid), 64'd0);
        chk("R11 illegal after reset", 64'(out_illegal), 64'd0);
        chk("R8 ready after reset", 64'(in_ready), 64'd1);

        // table walk: R1 R2 R3 R5 R6 R7 R9 R10
        for (int i = 0; i < NV; i++)
            send_insn(VEC[i][95:64], VEC[i][63:32], VEC[i][31:0], 0);

        // R12: gaps between extension words
        send_insn(VEC[6][95:64], VEC[6][63:32], VEC[6][31:0], 3);
        send_insn(VEC[4][95:64], VEC[4][63:32], VEC[4][31:0], 2);

        // R4: immediate routed to destination, with a two-word mode; next word is an instruction
        send_illegal({6'h30,2'd0,2'd0,2'd3,2'd1,3'd5,5'd1,5'd2,5'd3});
        send_insn(VEC[0][95:64], 32'h0, 32'h0, 0);
        // R4: both routes on source B
        send_illegal({6'h31,2'd1,2'd0,2'd2,2'd2,3'd4,5'd1,5'd2,5'd3});
        send_insn(VEC[3][95:64], 32'h0, 32'h0, 0);

        // R8: back-to-back instructions without idle cycles
        @(negedge clk);
        in_valid = 1'b1; in_word = VEC[1][95:64];
        @(negedge clk);
        in_word = VEC[2][95:64];
        chk("R8 first of pair", 64'(out_opcode), 64'h3F);
        @(negedge clk);
        in_valid = 1'b0;
        check_record(VEC[2][95:64], 32'h0, 32'h0);

        // R11: reset in mid-sequence abandons collection
        @(negedge clk);
        in_valid = 1'b1; in_word = VEC[6][95:64];
        @(negedge clk);
        in_valid = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 no record after abort", 64'(out_valid), 64'd0);
        send_insn(VEC[0][95:64], 32'h0, 32'h0, 0);

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule